// File: doc/BRIEF.md
# FIFO Watermark Interrupt Status Unit

This unit gathers interrupt conditions for a serial controller with a transmit FIFO and a receive FIFO. It compares the live FIFO fill levels with two programmable watermarks to form level-driven status bits. It also latches one-cycle error pulses from the transfer engine into sticky bits. Each status bit passes through its own mask bit, and the masked bits are ORed onto one interrupt line.

Software reaches the unit through a simple register write strobe with a select and a data word, plus a read select that returns a register's contents combinationally. Sticky bits are cleared by writing ones. Mask bits are turned on by writing ones to one address and turned off by writing ones to another. A controller abort returns both watermarks to 1.

Top module: `fifo_irq_status`

## Requirements
- R1: After reset both watermarks read 1, the mask reads 0, both sticky bits read 0 and irq_o is low.
- R2: Status bit 1 (TX has room) is high, in the same cycle, whenever tx_level_i is strictly below the TX watermark.
- R3: Status bit 2 (RX threshold) is high whenever rx_level_i is at or above the RX watermark. Status bit 4 (RX holds data) is high whenever rx_level_i is nonzero. Both follow the levels in the same cycle.
- R4: A one-cycle pulse on rx_drop_i sets sticky status bit 0 (RX overrun), and a pulse on tx_starve_i sets sticky status bit 3 (TX underflow), both from the next cycle. The bits stay set after the pulse ends.
- R5: A write to select 0 (status) clears each sticky bit whose data bit is 1. Data bits of 0 leave the sticky bits unchanged, and level bits are not affected.
- R6: When a set pulse and a write-one clear hit the same sticky bit in the same cycle, the bit is set afterwards.
- R7: A write to select 4 (TX watermark) or select 5 (RX watermark) stores a value of 1 to 63. A value of 0 or above 63 is ignored and the old value is kept.
- R8: abort_i sets both watermarks to 1 on the next cycle, taking priority over a watermark write in the same cycle.
- R9: Writing to select 1 turns on each mask bit whose data bit is 1, and writing to select 2 turns off each mask bit whose data bit is 1. Zero data bits leave the mask unchanged. The mask reads back at selects 1, 2 and 3.
- R10: irq_o is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | LVL_W | Current TX FIFO fill level |
| rx_level_i | input | LVL_W | Current RX FIFO fill level |
| rx_drop_i | input | 1 | Pulse: RX word dropped because the FIFO was full |
| tx_starve_i | input | 1 | Pulse: TX data was needed but the FIFO was empty |
| abort_i | input | 1 | Controller abort; resets watermarks |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for write |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 3 | Register select for read |
| rd_data_o | output | DW | Read data, combinational |
| irq_o | output | 1 | Masked interrupt output |

## Verification
The level comparisons are checked with a table of watermark and level pairs placed just below, exactly at, and just above each watermark, and at the extremes 0, 1, 63 and 64. Each row separates the strict less-than used for TX from the at-or-above test used for RX, and it also shows that the not-empty bit does not depend on the watermark. Directed sequences then separate a held sticky bit from a level bit, a zero-data write from a clear, and a set that wins from a clear that wins. They also separate an accepted watermark from a rejected one, and an abort from a plain write.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int unsigned NST       = 5;
  localparam int unsigned ST_RX_OVR = 0;
  localparam int unsigned ST_TX_ROOM = 1;
  localparam int unsigned ST_RX_THR = 2;
  localparam int unsigned ST_TX_UNF = 3;
  localparam int unsigned ST_RX_NE  = 4;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_IRQ_ON = 3'd1,
    SEL_IRQ_OFF = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_TX_WM  = 3'd4,
    SEL_RX_WM  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/fis_set_clr.sv
// Bank of set/clear flops, set has priority.
module fis_set_clr #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/fis_wm_reg.sv
module fis_wm_reg #(
  parameter int unsigned DW     = 8,
  parameter int unsigned WM_MAX = 63,
  localparam int unsigned WM_W  = $clog2(WM_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   data_i,
  output logic [WM_W-1:0] wm_o
);
  logic legal;
  assign legal = (data_i != '0) && (data_i <= DW'(WM_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wm_o <= WM_W'(1);
    else if (abort_i)        wm_o <= WM_W'(1);
    else if (wr_i && legal)  wm_o <= data_i[WM_W-1:0];
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fis_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned LVL_W  = 7,
  parameter int unsigned WM_MAX = 63,
  localparam int unsigned WM_W  = $clog2(WM_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_drop_i,
  input  logic             tx_starve_i,
  input  logic             abort_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [2:0]       rd_sel_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             irq_o
);
  logic [1:0][WM_W-1:0] wm_q;
  logic [WM_W-1:0]      tx_wm_q, rx_wm_q;
  logic [NST-1:0]       sticky_set, sticky_clr, sticky_q;
  logic [NST-1:0]       mask_set, mask_clr, mask_q;
  logic [NST-1:0]       status;
  logic [NST-1:0]       wdat;

  assign wdat = wr_data_i[NST-1:0];

  // index 0: TX watermark, index 1: RX watermark
  for (genvar g = 0; g < 2; g++) begin : g_wm
    fis_wm_reg #(.DW(DW), .WM_MAX(WM_MAX)) u_wm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .abort_i(abort_i),
      .wr_i   (wr_en_i && (wr_sel_i == 3'(SEL_TX_WM + g))),
      .data_i (wr_data_i),
      .wm_o   (wm_q[g])
    );
  end
  assign tx_wm_q = wm_q[0];
  assign rx_wm_q = wm_q[1];

  always_comb begin
    sticky_set = '0;
    sticky_set[ST_RX_OVR] = rx_drop_i;
    sticky_set[ST_TX_UNF] = tx_starve_i;
    sticky_clr = '0;
    if (wr_en_i && wr_sel_i == SEL_STATUS) begin
      sticky_clr[ST_RX_OVR] = wdat[ST_RX_OVR];
      sticky_clr[ST_TX_UNF] = wdat[ST_TX_UNF];
    end
  end

  fis_set_clr #(.N(NST)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_q)
  );

  assign mask_set = (wr_en_i && wr_sel_i == SEL_IRQ_ON)  ? wdat : '0;
  assign mask_clr = (wr_en_i && wr_sel_i == SEL_IRQ_OFF) ? wdat : '0;

  fis_set_clr #(.N(NST)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .q_o   (mask_q)
  );

  always_comb begin
    status = '0;
    status[ST_RX_OVR]  = sticky_q[ST_RX_OVR];
    status[ST_TX_UNF]  = sticky_q[ST_TX_UNF];
    status[ST_TX_ROOM] = tx_level_i < LVL_W'(tx_wm_q);
    status[ST_RX_THR]  = rx_level_i >= LVL_W'(rx_wm_q);
    status[ST_RX_NE]   = rx_level_i != '0;
  end

  assign irq_o = |(status & mask_q);

  always_comb begin
    case (rd_sel_i)
      SEL_STATUS:                       rd_data_o = DW'(status);
      SEL_IRQ_ON, SEL_IRQ_OFF, SEL_MASK: rd_data_o = DW'(mask_q);
      SEL_TX_WM:                        rd_data_o = DW'(tx_wm_q);
      SEL_RX_WM:                        rd_data_o = DW'(rx_wm_q);
      default:                          rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/fis_chk.sv
module fis_chk
  import fis_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned WM_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rx_drop_i,
  input logic            tx_starve_i,
  input logic            abort_i,
  input logic            wr_en_i,
  input logic [2:0]      wr_sel_i,
  input logic [DW-1:0]   wr_data_i,
  input logic            irq_o,
  input logic [NST-1:0]  sticky_q,
  input logic [NST-1:0]  mask_q,
  input logic [WM_W-1:0] tx_wm_q,
  input logic [WM_W-1:0] rx_wm_q
);
  // R4
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop_i |=> sticky_q[ST_RX_OVR]);
  // R4
  unf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_starve_i |=> sticky_q[ST_TX_UNF]);
  // R5
  ovr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_STATUS && wr_data_i[ST_RX_OVR] && !rx_drop_i)
      |=> !sticky_q[ST_RX_OVR]);
  // R7
  tx_wm_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_TX_WM && wr_data_i == '0 && !abort_i)
      |=> $stable(tx_wm_q));
  // R8
  abort_wm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tx_wm_q == WM_W'(1) && rx_wm_q == WM_W'(1)));
  // R10
  no_mask_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind fifo_irq_status fis_chk #(.DW(DW), .WM_W(WM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_drop_i  (rx_drop_i),
  .tx_starve_i(tx_starve_i),
  .abort_i    (abort_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .irq_o      (irq_o),
  .sticky_q   (sticky_q),
  .mask_q     (mask_q),
  .tx_wm_q    (tx_wm_q),
  .rx_wm_q    (rx_wm_q)
);

// File: tb/tb_fifo_irq_status.sv
module tb_fifo_irq_status;
  localparam int DW = 8;
  localparam int LVL_W = 7;

  logic             clk_i = 0;
  logic             rst_ni = 0;
  logic [LVL_W-1:0] tx_level_i = '0, rx_level_i = '0;
  logic             rx_drop_i = 0, tx_starve_i = 0, abort_i = 0;
  logic             wr_en_i = 0;
  logic [2:0]       wr_sel_i = '0, rd_sel_i = '0;
  logic [DW-1:0]    wr_data_i = '0, rd_data_o;
  logic             irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fifo_irq_status #(.DW(DW), .LVL_W(LVL_W)) dut (.*);

  // tx_wm(6) rx_wm(6) tx_lvl(7) rx_lvl(7) exp_status(5)
  localparam logic [30:0] VEC [8] = '{
    {6'd1,  6'd1,  7'd0,  7'd0,  5'b00010},
    {6'd1,  6'd1,  7'd1,  7'd1,  5'b10100},
    {6'd32, 6'd16, 7'd31, 7'd15, 5'b10010},
    {6'd32, 6'd16, 7'd32, 7'd16, 5'b10100},
    {6'd63, 6'd63, 7'd62, 7'd63, 5'b10110},
    {6'd63, 6'd63, 7'd64, 7'd64, 5'b10100},
    {6'd5,  6'd40, 7'd10, 7'd39, 5'b10000},
    {6'd63, 6'd1,  7'd0,  7'd64, 5'b10110}
  };

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [DW-1:0] v);
    rd_sel_i = sel;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    rd(3'd4, v); chk("R1 tx_wm", v, 8'd1);
    rd(3'd5, v); chk("R1 rx_wm", v, 8'd1);
    rd(3'd3, v); chk("R1 mask", v, 8'd0);
    rd(3'd0, v); chk("R1 sticky", v & 8'h09, 8'd0);
    chk("R1 irq", irq_o, 1'b0);

    // R2 R3 level table, R7 legal writes
    foreach (VEC[i]) begin
      wr(3'd4, DW'(VEC[i][30:25]));
      wr(3'd5, DW'(VEC[i][24:19]));
      tx_level_i = VEC[i][18:12];
      rx_level_i = VEC[i][11:5];
      rd(3'd0, v); chk("R2/R3 level status", v, DW'(VEC[i][4:0]));
      rd(3'd4, v); chk("R7 tx_wm stored", v, DW'(VEC[i][30:25]));
    end
    tx_level_i = 7'd10; rx_level_i = '0;

    // R7 illegal values ignored (tx_wm=63 rx_wm=1 now)
    wr(3'd4, 8'd0);   rd(3'd4, v); chk("R7 tx_wm zero ignored", v, 8'd63);
    wr(3'd4, 8'd64);  rd(3'd4, v); chk("R7 tx_wm 64 ignored", v, 8'd63);
    wr(3'd5, 8'd200); rd(3'd5, v); chk("R7 rx_wm 200 ignored", v, 8'd1);
    wr(3'd5, 8'd20);  rd(3'd5, v); chk("R7 rx_wm 20 taken", v, 8'd20);

    // R8 abort, and priority over same-cycle write
    abort_i = 1; @(negedge clk_i); abort_i = 0;
    rd(3'd4, v); chk("R8 tx_wm abort", v, 8'd1);
    rd(3'd5, v); chk("R8 rx_wm abort", v, 8'd1);
    abort_i = 1; wr(3'd4, 8'd30); abort_i = 0;
    rd(3'd4, v); chk("R8 abort beats write", v, 8'd1);

    // R4 sticky set and hold; status with tx_lvl=10 >= wm 1, rx 0: level bits 0
    rx_drop_i = 1; @(negedge clk_i); rx_drop_i = 0;
    repeat (2) @(negedge clk_i);
    rd(3'd0, v); chk("R4 overrun held", v, 8'h01);
    tx_starve_i = 1; @(negedge clk_i); tx_starve_i = 0;
    rd(3'd0, v); chk("R4 underflow held", v, 8'h09);

    // R5 zero data no effect, selective clear
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R5 zero write no effect", v, 8'h09);
    wr(3'd0, 8'h01); rd(3'd0, v); chk("R5 clear overrun only", v, 8'h08);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R5 clear all", v, 8'h00);

    // R6 set wins
    rx_drop_i = 1; wr(3'd0, 8'h01); rx_drop_i = 0;
    rd(3'd0, v); chk("R6 set beats clear", v, 8'h01);

    // R9 mask on/off
    wr(3'd1, 8'h00); rd(3'd3, v); chk("R9 zero on no effect", v, 8'h00);
    wr(3'd1, 8'h05); rd(3'd3, v); chk("R9 mask on", v, 8'h05);
    wr(3'd1, 8'h02); rd(3'd1, v); chk("R9 mask accumulates", v, 8'h07);
    wr(3'd2, 8'h04); rd(3'd2, v); chk("R9 mask off", v, 8'h03);

    // R10 irq: status=0x01 overrun, mask=0x03
    #0.5; chk("R10 irq from overrun", irq_o, 1'b1);
    wr(3'd0, 8'h01); #0.5; chk("R10 irq low after clear", irq_o, 1'b0);
    tx_level_i = 7'd0; #0.5; chk("R10 irq from tx room", irq_o, 1'b1);
    wr(3'd2, 8'h02); #0.5; chk("R10 irq masked off", irq_o, 1'b0);
    rx_level_i = 7'd5; #0.5; chk("R10 unmasked rx bits no irq", irq_o, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule